// File: doc/BRIEF.md
# UART Channel Interrupt Identifier

This block sits in one channel of a serial port controller and decides which interrupt the host is told about. It takes seven conditions from the receiver, transmitter, modem and flow-control logic around it. Some are live levels; others are one-cycle events that the block latches. It masks each against an enable register, ranks what is left by a fixed priority and shows the winner as a 6-bit identification code. An active-low request output is low whenever any enabled source is pending.

Each latched source has its own clear rule, tied to a host access: reading the status, receive-data or modem registers, writing transmit data, seeing a flow-resume character, or reading the identification code itself. A read of the identification code can last several cycles. The code is captured on the first cycle of that read and held until the read ends. A clear that depends on the read acts on the source the host was actually shown.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `id_code` is 000001, `irq_n` is 1 and all enable bits are 0.
- R2: Priority, highest first, with codes: line status 000110, RX time-out 001100, RX data 000100, transmit-empty 000010, modem change 000000, flow character 010000, RTS/CTS inactive 100000. With nothing enabled and pending, the code is 000001.
- R3: Line status is pending while `err_in_fifo` is high, or while a latched overrun is held. A pulse on `overrun_set` latches the overrun, and `rd_lsr` clears it.
- R4: RX data is pending while `rx_trig_lvl` is high. A pulse on `rx_tmo_set` latches the time-out, and `rd_rhr` clears it.
- R5: A pulse on `thr_set` latches transmit-empty. Either `wr_thr` clears it, or the first cycle of an identification read that reports 000010 does. An identification read that reports a higher source leaves it pending.
- R6: A pulse on `modem_set` latches the modem change, and `rd_msr` clears it.
- R7: `xoff_det` or `spec_det` latches the flow-character source and records the cause; `xoff_det` wins if both arrive together. An xoff cause clears only on `xon_det`. A special-character cause ignores `xon_det` and clears only on an identification read that reports 010000.
- R8: A pulse on `flow_set` latches the RTS/CTS source, which clears on the first cycle of an identification read that reports 100000.
- R9: The enable bits are written through `en_we`/`en_wdata`. Bit 0 covers RX time-out and RX data, bit 1 transmit-empty, bit 2 line status, bit 3 modem change, bit 4 flow character and bit 5 RTS/CTS. A disabled source is neither reported nor drives `irq_n`, but its latch is kept. With all enable bits 0, `irq_n` stays 1.
- R10: Outside an identification read, `irq_n` is 0 exactly when `id_code` is not 000001.
- R11: While `rd_iir` stays high, `id_code` keeps the value it showed in the first cycle of the read.
- R12: If a set pulse and a clear condition for the same latch arrive in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | New enable bits |
| err_in_fifo | input | 1 | Level: an erroneous character is still in the RX FIFO |
| overrun_set | input | 1 | Pulse: receive overrun occurred |
| rx_trig_lvl | input | 1 | Level: RX data ready or trigger level reached |
| rx_tmo_set | input | 1 | Pulse: RX character time-out |
| thr_set | input | 1 | Pulse: transmit holding empty or trigger passed |
| modem_set | input | 1 | Pulse: modem input change |
| xoff_det | input | 1 | Pulse: xoff character received |
| spec_det | input | 1 | Pulse: special character received |
| xon_det | input | 1 | Pulse: xon character received |
| flow_set | input | 1 | Pulse: RTS or CTS went inactive |
| rd_iir | input | 1 | High for the whole identification read access |
| rd_lsr | input | 1 | Line-status register read |
| rd_rhr | input | 1 | Receive data register read |
| rd_msr | input | 1 | Modem-status register read |
| wr_thr | input | 1 | Transmit data register write |
| id_code | output | 6 | Identification code of the highest pending source |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
On every cycle, the assertions check several properties. The returned code is always one of the eight legal values, and the code stays frozen during a multi-cycle identification read. Every latch obeys set-over-clear. A disabled enable register keeps the request high. The request agrees with the code outside a read. Two protections are also checked each cycle: an xoff-caused flow source survives an identification read, and a special-character one survives an xon.

Only the bench's scenarios show the following: the actual ranking between sources, the mapping of each enable bit, and which host access clears which source. The same goes for the side-effect clear of transmit-empty and RTS/CTS only when they are reported. A long randomized run against a bench reference model covers interleavings of events, clears and reads of varying length.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int CODE_W = 6;
    localparam int EN_W   = 6;
    localparam int NSRC   = 7;
    localparam int NLAT   = 5;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_NONE = 6'b000001;
    localparam code_t CODE_LINE = 6'b000110;
    localparam code_t CODE_TMO  = 6'b001100;
    localparam code_t CODE_RXD  = 6'b000100;
    localparam code_t CODE_THR  = 6'b000010;
    localparam code_t CODE_MDM  = 6'b000000;
    localparam code_t CODE_XOFF = 6'b010000;
    localparam code_t CODE_FLOW = 6'b100000;

    // source index == rank, 0 is highest priority
    localparam int SRC_LINE = 0;
    localparam int SRC_TMO  = 1;
    localparam int SRC_RXD  = 2;
    localparam int SRC_THR  = 3;
    localparam int SRC_MDM  = 4;
    localparam int SRC_XOFF = 5;
    localparam int SRC_FLOW = 6;

    // enable register bit positions
    localparam int EN_RX   = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
    localparam int EN_XOFF = 4;
    localparam int EN_FLOW = 5;

    // latched event slots
    localparam int L_OVR = 0;
    localparam int L_TMO = 1;
    localparam int L_THR = 2;
    localparam int L_MDM = 3;
    localparam int L_FLW = 4;

    function automatic code_t src_code(input int idx);
        case (idx)
            SRC_LINE: return CODE_LINE;
            SRC_TMO:  return CODE_TMO;
            SRC_RXD:  return CODE_RXD;
            SRC_THR:  return CODE_THR;
            SRC_MDM:  return CODE_MDM;
            SRC_XOFF: return CODE_XOFF;
            SRC_FLOW: return CODE_FLOW;
            default:  return CODE_NONE;
        endcase
    endfunction

    function automatic logic code_legal(input code_t c);
        return (c == CODE_NONE) || (c == CODE_LINE) || (c == CODE_TMO) ||
               (c == CODE_RXD)  || (c == CODE_THR)  || (c == CODE_MDM) ||
               (c == CODE_XOFF) || (c == CODE_FLOW);
    endfunction

endpackage

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end

        // R12
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);

        // R3
        clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !q[i]);
    end

endmodule

// File: rtl/uirq_flowchar.sv
module uirq_flowchar (
    input  logic clk,
    input  logic rst,
    input  logic xoff_det,
    input  logic spec_det,
    input  logic xon_det,
    input  logic iir_clr,
    output logic pend
);

    logic is_spec;
    logic arrive;
    logic drop;

    assign arrive = xoff_det | spec_det;
    assign drop   = pend & ((xon_det & ~is_spec) | (iir_clr & is_spec));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            is_spec <= 1'b0;
        end else if (arrive) begin
            pend    <= 1'b1;
            is_spec <= ~xoff_det;
        end else if (drop) begin
            pend    <= 1'b0;
        end
    end

    // R7
    xoff_keeps_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !is_spec && iir_clr && !xon_det && !arrive) |=> pend);

    // R7
    spec_keeps_on_xon_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && is_spec && xon_det && !iir_clr && !arrive) |=> pend);

endmodule

// File: rtl/uirq_rank.sv
module uirq_rank
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output code_t           code
);

    always_comb begin
        code = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) code = src_code(i);
        end
    end

    // R2
    code_legal_chk: assert final (code_legal(code));

endmodule

// File: rtl/uirq_read_hold.sv
module uirq_read_hold
    import uirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_iir,
    input  code_t live,
    output logic  start,
    output code_t id_out
);

    logic  hold_vld;
    code_t hold;

    assign start  = rd_iir & ~hold_vld;
    assign id_out = (rd_iir && hold_vld) ? hold : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold     <= CODE_NONE;
        end else begin
            hold_vld <= rd_iir;
            if (start) hold <= live;
        end
    end

    // R11
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && hold_vld) |-> (id_out == $past(id_out)));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en_we,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            err_in_fifo,
    input  logic            overrun_set,
    input  logic            rx_trig_lvl,
    input  logic            rx_tmo_set,
    input  logic            thr_set,
    input  logic            modem_set,
    input  logic            xoff_det,
    input  logic            spec_det,
    input  logic            xon_det,
    input  logic            flow_set,
    input  logic            rd_iir,
    input  logic            rd_lsr,
    input  logic            rd_rhr,
    input  logic            rd_msr,
    input  logic            wr_thr,
    output logic [CODE_W-1:0] id_code,
    output logic            irq_n
);

    logic [EN_W-1:0] en_q;
    logic [NLAT-1:0] lat_set;
    logic [NLAT-1:0] lat_clr;
    logic [NLAT-1:0] lat_q;
    logic [NSRC-1:0] pend;
    logic            xoff_pend;
    logic            iir_start;
    code_t           live;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    // event latches and their clear rules
    always_comb begin
        lat_set        = '0;
        lat_clr        = '0;
        lat_set[L_OVR] = overrun_set;
        lat_clr[L_OVR] = rd_lsr;
        lat_set[L_TMO] = rx_tmo_set;
        lat_clr[L_TMO] = rd_rhr;
        lat_set[L_THR] = thr_set;
        lat_clr[L_THR] = wr_thr | (iir_start && live == CODE_THR);
        lat_set[L_MDM] = modem_set;
        lat_clr[L_MDM] = rd_msr;
        lat_set[L_FLW] = flow_set;
        lat_clr[L_FLW] = iir_start && live == CODE_FLOW;
    end

    uirq_flag_bank #(.N(NLAT)) i_flags (
        .clk (clk),
        .rst (rst),
        .set (lat_set),
        .clr (lat_clr),
        .q   (lat_q)
    );

    uirq_flowchar i_flowchar (
        .clk      (clk),
        .rst      (rst),
        .xoff_det (xoff_det),
        .spec_det (spec_det),
        .xon_det  (xon_det),
        .iir_clr  (iir_start && live == CODE_XOFF),
        .pend     (xoff_pend)
    );

    // masking against the enable register
    always_comb begin
        pend           = '0;
        pend[SRC_LINE] = en_q[EN_LINE] & (err_in_fifo | lat_q[L_OVR]);
        pend[SRC_TMO]  = en_q[EN_RX]   & lat_q[L_TMO];
        pend[SRC_RXD]  = en_q[EN_RX]   & rx_trig_lvl;
        pend[SRC_THR]  = en_q[EN_THR]  & lat_q[L_THR];
        pend[SRC_MDM]  = en_q[EN_MDM]  & lat_q[L_MDM];
        pend[SRC_XOFF] = en_q[EN_XOFF] & xoff_pend;
        pend[SRC_FLOW] = en_q[EN_FLOW] & lat_q[L_FLW];
    end

    uirq_rank i_rank (
        .pend (pend),
        .code (live)
    );

    uirq_read_hold i_hold (
        .clk    (clk),
        .rst    (rst),
        .rd_iir (rd_iir),
        .live   (live),
        .start  (iir_start),
        .id_out (id_code)
    );

    assign irq_n = (live == CODE_NONE);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (irq_n && id_code == CODE_NONE));

    // R9
    polled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> irq_n);

    // R10
    irq_follows_code_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_iir |-> (irq_n == (id_code == CODE_NONE)));

    // R5
    thr_survives_higher_chk: assert property (@(posedge clk) disable iff (rst)
        (iir_start && live == CODE_LINE && lat_q[L_THR] && !wr_thr) |=> lat_q[L_THR]);

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    localparam logic [5:0] K_NONE = 6'b000001, K_LINE = 6'b000110, K_TMO = 6'b001100,
                           K_RXD = 6'b000100, K_THR = 6'b000010, K_MDM = 6'b000000,
                           K_XOFF = 6'b010000, K_FLOW = 6'b100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_we = 0;
    logic [5:0] en_wdata = 0;
    logic err_in_fifo = 0, overrun_set = 0, rx_trig_lvl = 0, rx_tmo_set = 0;
    logic thr_set = 0, modem_set = 0, xoff_det = 0, spec_det = 0, xon_det = 0;
    logic flow_set = 0, rd_iir = 0, rd_lsr = 0, rd_rhr = 0, rd_msr = 0, wr_thr = 0;
    logic [5:0] id_code;
    logic irq_n;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    // reference model state
    logic [5:0] m_en = 0;
    logic m_ovr = 0, m_tmo = 0, m_thr = 0, m_mdm = 0, m_flw = 0;
    logic m_xp = 0, m_xs = 0, m_hv = 0;
    logic [5:0] m_hold = 6'b000001;

    always #2.5 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
        .err_in_fifo(err_in_fifo), .overrun_set(overrun_set), .rx_trig_lvl(rx_trig_lvl),
        .rx_tmo_set(rx_tmo_set), .thr_set(thr_set), .modem_set(modem_set),
        .xoff_det(xoff_det), .spec_det(spec_det), .xon_det(xon_det), .flow_set(flow_set),
        .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rhr(rd_rhr), .rd_msr(rd_msr), .wr_thr(wr_thr),
        .id_code(id_code), .irq_n(irq_n)
    );

    function automatic logic [5:0] m_live();
        if (m_en[2] && (err_in_fifo || m_ovr)) return K_LINE;
        if (m_en[0] && m_tmo)                  return K_TMO;
        if (m_en[0] && rx_trig_lvl)            return K_RXD;
        if (m_en[1] && m_thr)                  return K_THR;
        if (m_en[3] && m_mdm)                  return K_MDM;
        if (m_en[4] && m_xp)                   return K_XOFF;
        if (m_en[5] && m_flw)                  return K_FLOW;
        return K_NONE;
    endfunction

    function automatic logic [5:0] m_out();
        return (rd_iir && m_hv) ? m_hold : m_live();
    endfunction

    task automatic m_step();
        logic [5:0] lv;
        logic st;
        lv = m_live();
        st = rd_iir && !m_hv;
        if (st) m_hold = lv;
        m_hv = rd_iir;
        if (en_we) m_en = en_wdata;
        if (overrun_set) m_ovr = 1; else if (rd_lsr) m_ovr = 0;
        if (rx_tmo_set)  m_tmo = 1; else if (rd_rhr) m_tmo = 0;
        if (thr_set)     m_thr = 1; else if (wr_thr || (st && lv == K_THR)) m_thr = 0;
        if (modem_set)   m_mdm = 1; else if (rd_msr) m_mdm = 0;
        if (flow_set)    m_flw = 1; else if (st && lv == K_FLOW) m_flw = 0;
        if (xoff_det || spec_det) begin
            m_xp = 1; m_xs = !xoff_det;
        end else if (m_xp && ((xon_det && !m_xs) || (st && lv == K_XOFF && m_xs))) begin
            m_xp = 0;
        end
    endtask

    task automatic clr();
        en_we = 0; overrun_set = 0; rx_tmo_set = 0; thr_set = 0; modem_set = 0;
        xoff_det = 0; spec_det = 0; xon_det = 0; flow_set = 0;
        rd_iir = 0; rd_lsr = 0; rd_rhr = 0; rd_msr = 0; wr_thr = 0;
    endtask

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // inputs are already driven; sample, advance model, move to next negedge
    task automatic tick(input bit lit, input logic [5:0] ec, input string tag);
        #1;
        chk(tag, id_code, lit ? ec : m_out());
        chk("R10", {5'b0, irq_n}, {5'b0, (m_live() == K_NONE)});
        m_step();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int rd_left;
        void'($urandom(32'h1A2B3C4D));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        tick(1, K_NONE, "R1");
        en_we = 1; en_wdata = 6'h3F; tick(1, K_NONE, "R9");

        // transmit-empty cleared by reported read, modem by MSR read
        thr_set = 1;                 tick(1, K_NONE, "R5");
        modem_set = 1;               tick(1, K_THR,  "R2");
        rd_iir = 1;                  tick(1, K_THR,  "R5");
                                     tick(1, K_MDM,  "R5");
        rd_msr = 1;                  tick(1, K_MDM,  "R6");
                                     tick(1, K_NONE, "R6");

        // xoff cause and RTS/CTS source
        flow_set = 1;                tick(1, K_NONE, "R8");
        xoff_det = 1;                tick(1, K_FLOW, "R8");
                                     tick(1, K_XOFF, "R7");
        rd_iir = 1;                  tick(1, K_XOFF, "R7");
                                     tick(1, K_XOFF, "R7");
        xon_det = 1;                 tick(1, K_XOFF, "R7");
                                     tick(1, K_FLOW, "R7");
        rd_iir = 1;                  tick(1, K_FLOW, "R8");
                                     tick(1, K_NONE, "R8");

        // special-character cause
        spec_det = 1;                tick(1, K_NONE, "R7");
                                     tick(1, K_XOFF, "R7");
        xon_det = 1;                 tick(1, K_XOFF, "R7");
                                     tick(1, K_XOFF, "R7");
        rd_iir = 1;                  tick(1, K_XOFF, "R7");
                                     tick(1, K_NONE, "R7");

        // receive sources
        rx_trig_lvl = 1;             tick(1, K_RXD,  "R4");
        rx_tmo_set = 1;              tick(1, K_RXD,  "R4");
                                     tick(1, K_TMO,  "R2");
        rd_rhr = 1;                  tick(1, K_TMO,  "R4");
                                     tick(1, K_RXD,  "R4");
        rx_trig_lvl = 0;             tick(1, K_NONE, "R4");

        // line status
        err_in_fifo = 1;             tick(1, K_LINE, "R3");
        err_in_fifo = 0; overrun_set = 1; tick(1, K_NONE, "R3");
                                     tick(1, K_LINE, "R3");
        rd_lsr = 1;                  tick(1, K_LINE, "R3");
                                     tick(1, K_NONE, "R3");

        // set wins over clear
        thr_set = 1; wr_thr = 1;     tick(1, K_NONE, "R12");
                                     tick(1, K_THR,  "R12");
        wr_thr = 1;                  tick(1, K_THR,  "R5");
                                     tick(1, K_NONE, "R5");

        // multi-cycle read holds its code
        thr_set = 1;                 tick(1, K_NONE, "R11");
        rd_iir = 1; modem_set = 1;   tick(1, K_THR,  "R11");
        rd_iir = 1;                  tick(1, K_THR,  "R11");
        rd_iir = 1;                  tick(1, K_THR,  "R11");
                                     tick(1, K_MDM,  "R11");
        rd_msr = 1;                  tick(1, K_MDM,  "R6");
                                     tick(1, K_NONE, "R6");

        // read reporting a higher source keeps transmit-empty
        err_in_fifo = 1; thr_set = 1; tick(1, K_LINE, "R5");
        rd_iir = 1;                  tick(1, K_LINE, "R5");
        err_in_fifo = 0;             tick(1, K_THR,  "R5");
        wr_thr = 1;                  tick(1, K_THR,  "R5");
                                     tick(1, K_NONE, "R5");

        // enable bit mapping and polled mode
        en_we = 1; en_wdata = 6'h00; tick(1, K_NONE, "R9");
        thr_set = 1; modem_set = 1; flow_set = 1; tick(1, K_NONE, "R9");
                                     tick(1, K_NONE, "R9");
        en_we = 1; en_wdata = 6'b000010; tick(1, K_NONE, "R9");
                                     tick(1, K_THR,  "R9");
        en_we = 1; en_wdata = 6'b001000; tick(1, K_THR, "R9");
                                     tick(1, K_MDM,  "R9");
        en_we = 1; en_wdata = 6'b100000; tick(1, K_MDM, "R9");
                                     tick(1, K_FLOW, "R9");
        wr_thr = 1; rd_msr = 1; rd_iir = 1; tick(1, K_FLOW, "R8");
                                     tick(1, K_NONE, "R8");
        en_we = 1; en_wdata = 6'h3F; tick(1, K_NONE, "R9");

        // randomized interleavings against the reference model (R2)
        rd_left = 0;
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 16) == 0) err_in_fifo = ~err_in_fifo;
            if (($urandom % 12) == 0) rx_trig_lvl = ~rx_trig_lvl;
            en_we = (($urandom % 40) == 0);
            en_wdata = 6'($urandom);
            overrun_set = (($urandom % 12) == 0);
            rx_tmo_set  = (($urandom % 12) == 0);
            thr_set     = (($urandom % 8) == 0);
            modem_set   = (($urandom % 12) == 0);
            xoff_det    = (($urandom % 20) == 0);
            spec_det    = (($urandom % 20) == 0);
            xon_det     = (($urandom % 10) == 0);
            flow_set    = (($urandom % 14) == 0);
            rd_lsr      = (($urandom % 10) == 0);
            rd_rhr      = (($urandom % 10) == 0);
            rd_msr      = (($urandom % 10) == 0);
            wr_thr      = (($urandom % 12) == 0);
            if (rd_left == 0 && ($urandom % 5) == 0) rd_left = 1 + int'($urandom % 3);
            rd_iir = (rd_left > 0);
            if (rd_left > 0) rd_left--;
            tick(0, 6'b0, "R2");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule